// File: doc/BRIEF.md
# Write-Update Snooping Cache Coherence Controller

This block keeps one small direct-mapped cache coherent with its peers on a shared bus, using an update-based scheme in which a line is never invalidated. Every line carries a Shared flag and a Dirty flag, so it is always in one of four states: exclusive-clean, exclusive-dirty, shared-clean or shared-dirty. A wired-OR sharing line on the bus tells the controller, on each of its own bus cycles, whether any other cache holds the same line. The controller samples that line and uses it to learn a line's sharing status again on each such cycle. When another agent reads or writes a line this cache holds, the controller drives the sharing line.

A processor write to an exclusive line stays local. A write to a shared line goes out on the bus, so that memory and every other copy pick up the new value. After reset the controller fills every line from memory before it serves the processor. In normal operation a line leaves only when a miss needs its slot, and a dirty victim is written back first. The processor holds its request steady until `cpu_ready` is high. Memory, the bus arbiter and the wired-OR gate itself are outside the block.

The controller has five states. BOOT is the reset fill. IDLE serves hits and snoops. WBACK writes back a dirty victim. FILL reads the missing line. WTHRU writes a shared line through to the bus. The transitions are BOOT→IDLE after the last index is filled, IDLE→WBACK on a miss with a dirty victim, IDLE→FILL on a miss with a clean victim, WBACK→FILL on acknowledge, FILL→IDLE on acknowledge, IDLE→WTHRU on a write hit to a shared line, and WTHRU→IDLE on acknowledge.

Top module: `wu_coh_ctrl`

## Requirements
- R1: From reset the controller is in BOOT. It issues one bus read for every line index in ascending order, using address `{tag 0, index}`. Each line is filled with the returned data and Dirty clear, and its Shared flag takes the value of `bus_shared_in` at the acknowledge. `cpu_ready` stays low until the last fill is done, and the controller then enters IDLE.
- R2: In IDLE, a read hit returns the line data on `cpu_rdata` with `cpu_ready` high in the same cycle and no bus request.
- R3: A write hit to an exclusive line completes in the same cycle with no bus request. It stores the data and sets Dirty.
- R4: A write hit to a shared line enters WTHRU. WTHRU issues one bus write of the processor address and data, and `cpu_ready` rises in the cycle of the acknowledge. The line keeps the data with Dirty clear.
- R5: At the WTHRU acknowledge, the line's Shared flag takes the value of `bus_shared_in`. A line therefore becomes exclusive after one write-through that no other cache claims, and its next write stays local.
- R6: A miss whose victim is clean goes IDLE→FILL. FILL issues one bus read of the requested address and refills the line with Dirty clear and Shared taken from `bus_shared_in`. Back in IDLE, the request is then served as a hit.
- R7: A miss whose victim has Dirty set goes through WBACK first. WBACK issues a bus write of the victim's address and data, and only then does FILL issue its read.
- R8: A snooped write (`snp_valid`, `snp_we`) that hits a local line raises `bus_shared_out` in the same cycle and overwrites the line data. It leaves the line shared-clean.
- R9: A snooped read that hits a line with Dirty set raises `snp_supply` and `bus_shared_out`, and drives the line data on `snp_rdata`. The line becomes shared-dirty.
- R10: A snooped read that hits a clean line raises `bus_shared_out` with `snp_supply` low. The line becomes shared.
- R11: A snoop whose tag differs from the tag stored at its index leaves `bus_shared_out` and `snp_supply` low and changes nothing.
- R12: `cpu_ready` is low in WBACK and FILL, and in WTHRU before the acknowledge. It is also low in IDLE while a hitting snoop targets the same line index as the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request pending |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data of the requested line |
| cpu_ready | output | 1 | Request completes this cycle (high in IDLE when nothing is pending) |
| bus_req | output | 1 | Bus transaction requested |
| bus_we | output | 1 | Bus transaction is a write |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Current bus transaction completes |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |
| bus_shared_in | input | 1 | Wired-OR sharing line from the other caches |
| bus_shared_out | output | 1 | This cache holds the snooped line |
| snp_valid | input | 1 | Another agent's bus transaction is visible |
| snp_we | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped write data |
| snp_supply | output | 1 | This cache supplies the snooped read data |
| snp_rdata | output | DATA_W | Data supplied for a snooped read |

## Verification
The bench builds the block with ADDR_W=6, IDX_W=2 and DATA_W=16. With only four lines and addresses drawn from three tags, random traffic hits, displaces dirty victims and meets snoops on held lines all within a few hundred operations. The 16-bit data keeps write-back and write-through values easy to tell apart. Bus acknowledges are delayed at random, so the stall windows of WBACK, FILL and WTHRU, and the state changes of each sharing outcome, are reached over and over.

// File: rtl/wu_pkg.sv
package wu_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_WTHRU
    } wu_state_e;

    typedef struct packed {
        logic shared;
        logic dirty;
    } wu_flags_t;

endpackage

// File: rtl/wu_line_store.sv
module wu_line_store
    import wu_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  c_idx,
    output logic [TAG_W-1:0]  c_tag,
    output wu_flags_t         c_flags,
    output logic [DATA_W-1:0] c_data,
    input  logic [IDX_W-1:0]  s_idx,
    output logic [TAG_W-1:0]  s_tag,
    output wu_flags_t         s_flags,
    output logic [DATA_W-1:0] s_data,
    input  logic              a_en,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [TAG_W-1:0]  a_tag,
    input  wu_flags_t         a_flags,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_en,
    input  logic [IDX_W-1:0]  b_idx,
    input  wu_flags_t         b_flags,
    input  logic              b_data_en,
    input  logic [DATA_W-1:0] b_data
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_q [LINES];
    wu_flags_t         flg_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    // Tag and flags: snoop port wins over the controller port on the same line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                flg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (b_en && b_idx == IDX_W'(i)) begin
                    flg_q[i] <= b_flags;
                end else if (a_en && a_idx == IDX_W'(i)) begin
                    tag_q[i] <= a_tag;
                    flg_q[i] <= a_flags;
                end
            end
        end
    end

    // Data array holds no reset; BOOT fills every line.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (b_en && b_data_en && b_idx == IDX_W'(i)) begin
                dat_q[i] <= b_data;
            end else if (a_en && a_idx == IDX_W'(i)) begin
                dat_q[i] <= a_data;
            end
        end
    end

    assign c_tag   = tag_q[c_idx];
    assign c_flags = flg_q[c_idx];
    assign c_data  = dat_q[c_idx];
    assign s_tag   = tag_q[s_idx];
    assign s_flags = flg_q[s_idx];
    assign s_data  = dat_q[s_idx];

endmodule

// File: rtl/wu_snoop.sv
module wu_snoop
    import wu_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [DATA_W-1:0] snp_wdata,
    input  logic              filled,
    input  logic [TAG_W-1:0]  line_tag,
    input  wu_flags_t         line_flags,
    input  logic [DATA_W-1:0] line_data,
    output logic              hit,
    output logic              supply,
    output logic [DATA_W-1:0] supply_data,
    output logic              upd_en,
    output wu_flags_t         upd_flags,
    output logic              upd_data_en,
    output logic [DATA_W-1:0] upd_data
);
    always_comb begin
        hit         = snp_valid && filled && (line_tag == snp_tag);
        supply      = hit && !snp_we && line_flags.dirty;
        supply_data = line_data;
        upd_en      = hit;
        upd_data_en = hit && snp_we;
        upd_data    = snp_wdata;
        upd_flags   = line_flags;
        upd_flags.shared = 1'b1;
        if (snp_we) begin
            upd_flags.dirty = 1'b0;
        end
    end

endmodule

// File: rtl/wu_ctrl.sv
module wu_ctrl
    import wu_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    input  logic              snp_conflict,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  wu_flags_t         line_flags,
    input  logic [DATA_W-1:0] line_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    output logic              a_en,
    output logic [IDX_W-1:0]  a_idx,
    output logic [ADDR_W-IDX_W-1:0] a_tag,
    output wu_flags_t         a_flags,
    output logic [DATA_W-1:0] a_data,
    output wu_state_e         state,
    output logic [IDX_W-1:0]  boot_cnt
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int LINES = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    wu_state_e        state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] cpu_idx;
    logic [TAG_W-1:0] cpu_tag;
    logic             hit;
    logic             go;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign hit     = (line_tag == cpu_tag);
    assign go      = cpu_req && !snp_conflict;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BOOT && bus_ack) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  if (bus_ack && cnt_q == LAST_IDX) state_d = ST_IDLE;
            ST_IDLE: begin
                if (go && !hit) begin
                    state_d = line_flags.dirty ? ST_WBACK : ST_FILL;
                end else if (go && cpu_we && line_flags.shared) begin
                    state_d = ST_WTHRU;
                end
            end
            ST_WBACK: if (bus_ack) state_d = ST_FILL;
            ST_FILL:  if (bus_ack) state_d = ST_IDLE;
            ST_WTHRU: if (bus_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        a_en      = 1'b0;
        a_idx     = cpu_idx;
        a_tag     = cpu_tag;
        a_flags   = '{shared: bus_shared_in, dirty: 1'b0};
        a_data    = bus_rdata;
        unique case (state_q)
            ST_BOOT: begin
                bus_req  = 1'b1;
                bus_addr = {{TAG_W{1'b0}}, cnt_q};
                a_en     = bus_ack;
                a_idx    = cnt_q;
                a_tag    = '0;
            end
            ST_IDLE: begin
                if (!cpu_req) begin
                    cpu_ready = 1'b1;
                end else if (go && hit && !cpu_we) begin
                    cpu_ready = 1'b1;
                end else if (go && hit && !line_flags.shared) begin
                    cpu_ready = 1'b1;
                    a_en      = 1'b1;
                    a_flags   = '{shared: 1'b0, dirty: 1'b1};
                    a_data    = cpu_wdata;
                end
            end
            ST_WBACK: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = {line_tag, cpu_idx};
                bus_wdata = line_data;
            end
            ST_FILL: begin
                bus_req = 1'b1;
                a_en    = bus_ack;
            end
            ST_WTHRU: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                cpu_ready = bus_ack;
                a_en      = bus_ack;
                a_data    = cpu_wdata;
            end
            default: ;
        endcase
    end

    assign state    = state_q;
    assign boot_cnt = cnt_q;

endmodule

// File: rtl/wu_coh_ctrl.sv
module wu_coh_ctrl
    import wu_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    output logic              bus_shared_out,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_wdata,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    wu_state_e         ctl_state;
    logic [IDX_W-1:0]  boot_cnt;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  c_tag, s_tag, a_tag;
    wu_flags_t         c_flags, s_flags, a_flags, b_flags;
    logic [DATA_W-1:0] c_data, s_data, a_data, b_data;
    logic              a_en, b_en, b_data_en;
    logic [IDX_W-1:0]  a_idx;
    logic              snp_hit, filled, snp_conflict;

    assign snp_idx      = snp_addr[IDX_W-1:0];
    assign filled       = (ctl_state != ST_BOOT) || (snp_idx < boot_cnt);
    assign snp_conflict = snp_hit && (snp_idx == cpu_addr[IDX_W-1:0]);
    assign cpu_rdata    = c_data;
    assign bus_shared_out = snp_hit;

    wu_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .c_idx(cpu_addr[IDX_W-1:0]), .c_tag(c_tag), .c_flags(c_flags), .c_data(c_data),
        .s_idx(snp_idx), .s_tag(s_tag), .s_flags(s_flags), .s_data(s_data),
        .a_en(a_en), .a_idx(a_idx), .a_tag(a_tag), .a_flags(a_flags), .a_data(a_data),
        .b_en(b_en), .b_idx(snp_idx), .b_flags(b_flags), .b_data_en(b_data_en), .b_data(b_data)
    );

    wu_snoop #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .snp_wdata(snp_wdata), .filled(filled),
        .line_tag(s_tag), .line_flags(s_flags), .line_data(s_data),
        .hit(snp_hit), .supply(snp_supply), .supply_data(snp_rdata),
        .upd_en(b_en), .upd_flags(b_flags), .upd_data_en(b_data_en), .upd_data(b_data)
    );

    wu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .snp_conflict(snp_conflict),
        .line_tag(c_tag), .line_flags(c_flags), .line_data(c_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
        .a_en(a_en), .a_idx(a_idx), .a_tag(a_tag), .a_flags(a_flags), .a_data(a_data),
        .state(ctl_state), .boot_cnt(boot_cnt)
    );

endmodule

// File: rtl/wu_coh_chk.sv
module wu_coh_chk
    import wu_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input wu_state_e state,
    input logic      cpu_ready,
    input logic      bus_req,
    input logic      bus_ack,
    input logic      bus_shared_out,
    input logic      snp_supply,
    input logic      snp_valid,
    input logic      snp_we
);
    p_boot_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BOOT |-> !cpu_ready);

    p_idle_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !bus_req);

    p_wthru_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WTHRU && bus_ack) |-> cpu_ready);

    p_fill_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && bus_ack) |=> state == ST_IDLE);

    p_wback_to_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBACK && bus_ack) |=> state == ST_FILL);

    p_shared_needs_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_shared_out |-> snp_valid);

    p_supply_read_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (bus_shared_out && snp_valid && !snp_we));

    p_bus_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !bus_ack) |-> !cpu_ready);

endmodule

bind wu_coh_ctrl wu_coh_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(ctl_state), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_shared_out(bus_shared_out),
    .snp_supply(snp_supply), .snp_valid(snp_valid), .snp_we(snp_we)
);

// File: tb/sim_wu_coh_ctrl.sv
module sim_wu_coh_ctrl;
    localparam int AW = 6;
    localparam int IW = 2;
    localparam int DW = 16;
    localparam int LINES = 1 << IW;
    localparam int MEMN = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic cpu_ready, bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic bus_ack = 0;
    logic [DW-1:0] bus_rdata = '0;
    logic bus_shared_in = 0;
    logic bus_shared_out;
    logic snp_valid = 0, snp_we = 0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_wdata = '0;
    logic snp_supply;
    logic [DW-1:0] snp_rdata;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] mem [MEMN];
    int            m_tag [LINES];
    bit            m_sh [LINES];
    bit            m_dirty [LINES];
    logic [DW-1:0] m_data [LINES];

    always #10 clk = ~clk;

    wu_coh_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (.*);

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic cpu_op(input string rq, input bit we, input int addr, input logic [DW-1:0] wd, input bit sh);
        int idx = addr % LINES;
        int tg = addr / LINES;
        int en = 0;
        bit ewe [4];
        int ea [4];
        logic [DW-1:0] ed [4];
        logic [DW-1:0] erd;
        bit rwe [8];
        int ra [8];
        logic [DW-1:0] rdv [8];
        int nb = 0;
        int cyc = 0;
        bit done = 0;
        logic [DW-1:0] got = '0;
        if (m_tag[idx] != tg) begin
            if (m_dirty[idx]) begin
                ewe[en] = 1; ea[en] = m_tag[idx] * LINES + idx; ed[en] = m_data[idx]; en++;
            end
            ewe[en] = 0; ea[en] = addr; ed[en] = '0; en++;
            m_tag[idx] = tg; m_data[idx] = mem[addr]; m_sh[idx] = sh; m_dirty[idx] = 0;
        end
        if (we) begin
            if (m_sh[idx]) begin
                ewe[en] = 1; ea[en] = addr; ed[en] = wd; en++;
                m_sh[idx] = sh; m_dirty[idx] = 0;
            end else begin
                m_dirty[idx] = 1;
            end
            m_data[idx] = wd;
        end
        erd = m_data[idx];
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = wd;
        while (!done && cyc < 60) begin
            #1;
            if (bus_req && ($urandom % 4 != 0)) begin
                if (nb < 8) begin rwe[nb] = bus_we; ra[nb] = int'(bus_addr); rdv[nb] = bus_wdata; end
                nb++;
                if (bus_we) mem[bus_addr] = bus_wdata;
                bus_rdata = mem[bus_addr];
                bus_shared_in = sh;
                bus_ack = 1;
                #1;
            end else if (bus_req) begin
                chk(!cpu_ready, "R12", "ready during bus wait", int'(cpu_ready), 0);
            end
            if (cpu_ready) begin
                done = 1;
                got = cpu_rdata;
            end
            @(posedge clk);
            #1;
            bus_ack = 0;
            if (!done) begin
                cyc++;
                @(negedge clk);
            end
        end
        cpu_req = 0;
        chk(done, rq, "request completed", int'(done), 1);
        chk(nb == en, rq, "bus transaction count", nb, en);
        if (en == 0) chk(cyc == 0, rq, "hit latency cycles", cyc, 0);
        for (int k = 0; k < en && k < nb; k++) begin
            chk(rwe[k] == ewe[k], rq, "bus direction", int'(rwe[k]), int'(ewe[k]));
            chk(ra[k] == ea[k], rq, "bus address", ra[k], ea[k]);
            if (ewe[k]) chk(rdv[k] == ed[k], rq, "bus write data", int'(rdv[k]), int'(ed[k]));
        end
        if (!we) chk(got == erd, rq, "read data", int'(got), int'(erd));
    endtask

    task automatic snoop_op(input string rq, input bit we, input int addr, input logic [DW-1:0] wd);
        int idx = addr % LINES;
        bit hit = (m_tag[idx] == addr / LINES);
        bit esup = hit && !we && m_dirty[idx];
        @(negedge clk);
        snp_valid = 1; snp_we = we; snp_addr = AW'(addr); snp_wdata = wd;
        #1;
        chk(bus_shared_out == hit, rq, "snoop shared out", int'(bus_shared_out), int'(hit));
        chk(snp_supply == esup, rq, "snoop supply", int'(snp_supply), int'(esup));
        if (esup) chk(snp_rdata == m_data[idx], rq, "supplied data", int'(snp_rdata), int'(m_data[idx]));
        @(posedge clk);
        #1;
        snp_valid = 0;
        if (hit) begin
            m_sh[idx] = 1;
            if (we) begin m_data[idx] = wd; m_dirty[idx] = 0; end
        end
        if (we) mem[addr] = wd;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        for (int a = 0; a < MEMN; a++) mem[a] = DW'(a * 37 + 5);
        repeat (3) @(posedge clk);
        #1;
        chk(!cpu_ready, "R1", "ready in reset", int'(cpu_ready), 0);
        chk(!bus_shared_out, "R1", "shared out in reset", int'(bus_shared_out), 0);
        @(negedge clk);
        rst_n = 1;
        // R1: bootstrap fill walk
        for (int i = 0; i < LINES; i++) begin
            #1;
            chk(!cpu_ready, "R1", "ready during boot", int'(cpu_ready), 0);
            chk(bus_req && !bus_we && int'(bus_addr) == i, "R1", "boot read address", int'(bus_addr), i);
            bus_rdata = mem[i]; bus_shared_in = (i == 1); bus_ack = 1;
            @(posedge clk);
            #1;
            bus_ack = 0;
            m_tag[i] = 0; m_data[i] = mem[i]; m_sh[i] = (i == 1); m_dirty[i] = 0;
            @(negedge clk);
        end
        #1;
        chk(cpu_ready && !bus_req, "R1", "idle after boot", int'(cpu_ready), 1);

        cpu_op("R2", 0, 0, 16'h0, 0);
        cpu_op("R1", 0, 1, 16'h0, 0);
        cpu_op("R3", 1, 0, 16'hA5A5, 0);
        snoop_op("R9", 0, 0, 16'h0);
        cpu_op("R4", 1, 0, 16'h1234, 0);
        chk(mem[0] == 16'h1234, "R4", "memory after write-through", int'(mem[0]), 16'h1234);
        cpu_op("R5", 1, 0, 16'h2222, 1);
        cpu_op("R7", 0, 4, 16'h0, 1);
        cpu_op("R5", 1, 4, 16'h3333, 1);
        cpu_op("R5", 1, 4, 16'h4444, 0);
        cpu_op("R5", 1, 4, 16'h5555, 0);
        snoop_op("R8", 1, 4, 16'h7777);
        cpu_op("R8", 0, 4, 16'h0, 0);
        cpu_op("R8", 1, 4, 16'h7878, 0);
        snoop_op("R11", 0, 8, 16'h0);
        snoop_op("R11", 1, 9, 16'hBEEF);
        cpu_op("R11", 0, 1, 16'h0, 0);
        snoop_op("R10", 0, 2, 16'h0);
        cpu_op("R10", 1, 2, 16'h6161, 0);
        cpu_op("R6", 0, 19, 16'h0, 0);
        cpu_op("R6", 1, 23, 16'h9191, 0);
        cpu_op("R7", 1, 27, 16'h9292, 1);

        // R12: snoop to the same line as a pending hit stalls the processor
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 6'd4;
        snp_valid = 1; snp_we = 0; snp_addr = 6'd4;
        #1;
        chk(!cpu_ready, "R12", "ready during same-line snoop", int'(cpu_ready), 0);
        chk(bus_shared_out, "R12", "snoop hit during stall", int'(bus_shared_out), 1);
        @(posedge clk);
        #1;
        snp_valid = 0;
        m_sh[0] = 1;
        @(negedge clk);
        #1;
        chk(cpu_ready, "R12", "ready after snoop", int'(cpu_ready), 1);
        chk(cpu_rdata == m_data[0], "R12", "read data after stall", int'(cpu_rdata), int'(m_data[0]));
        @(posedge clk);
        #1;
        cpu_req = 0;

        // Constrained random mix
        for (int n = 0; n < 500; n++) begin
            int a = int'(($urandom % 3) * LINES + ($urandom % LINES));
            if ($urandom % 10 < 7) begin
                cpu_op("R2/R3/R4/R5/R6/R7", bit'($urandom % 2), a, DW'($urandom), bit'($urandom % 2));
            end else begin
                snoop_op("R8/R9/R10/R11", bit'($urandom % 2), a, DW'($urandom));
            end
        end
        finish_run();
    end

endmodule